// File: doc/BRIEF.md
# Double-Buffered Dual-Mode Serial Transmitter

This block turns bytes written by a processor into a serial bit stream. The processor writes a byte into an 8-bit holding register through a small register bus. When the internal shifter has nothing left to send, it takes that byte. The holding register is then free for the next character. If the next byte is written while the current one is still shifting, characters leave back to back with no idle time between them.

An 8-bit mode register selects one of two line formats. The first is an asynchronous frame: a start bit, 7 or 8 data bits, optional parity of either sense, and one or two stop bits. The second is a clocked synchronous stream of 8 bits, sent with a serial clock output. A two-bit rate field sets a prescaler that divides the system clock. A standby input returns the registers to their initial values and stops any character in progress.

Top module: `dual_serial_tx`

## Requirements
- R1: After reset the mode register reads 0x04, the holding register reads 0xFF, tx_empty is 1, and both txd and sclk are 1. While no character is shifting, txd and sclk stay 1.
- R2: reg_addr=0 selects the mode register and reg_addr=1 selects the holding register. A write takes effect at the clock edge where reg_wr is high. reg_rdata shows the selected register combinationally. Mode bit 2 is reserved and always reads 1, whatever value is written.
- R3: A write to the holding register clears tx_empty. When the shifter is idle, the held byte moves into the shifter at the next clock edge, and tx_empty returns to 1 at that same edge.
- R4: In asynchronous mode (mode bit 7 = 0) the frame starts in the cycle after the byte moves into the shifter. The frame is: a 0 start bit; the data bits, LSB first; an optional parity bit; then stop bits at 1. Bit 6 selects 8 data bits (0) or 7 data bits (1). Bit 5 enables parity. Bit 4 selects even parity (0) or odd parity (1). Bit 3 selects one stop bit (0) or two (1).
- R5: Mode bits 1:0 (values 0, 1, 2, 3) divide the system clock by 1, 4, 16 or 64 to form the tick. An asynchronous bit lasts 16 ticks.
- R6: In synchronous mode (bit 7 = 1) exactly 8 data bits go out, LSB first, with no start, parity or stop bits, and bit 6 has no effect. Each bit lasts 2 ticks. sclk is 0 for the first tick and 1 for the second. In asynchronous mode sclk stays 1.
- R7: If the holding register is full when the last bit of a character ends, the next character's first bit follows in the very next cycle.
- R8: While standby is 1, the registers are held at their R1 values, bus writes are ignored, and a character in progress is abandoned, so txd returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Synchronous reinitialise, active high |
| reg_addr | input | 1 | Register select: 0 = mode, 1 = holding |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| txd | output | 1 | Serial data line, idle high |
| sclk | output | 1 | Serial clock for synchronous mode, idle high |
| tx_empty | output | 1 | Holding register is free for a new byte |

## Verification
A table of mode and data pairs is sent one pair at a time, and every bit is sampled at the middle of its bit time. The pairs cover 8 and 7 data bits, even parity, odd parity and no parity, one and two stop bits, and all four rate selects. Synchronous entries are included, one of them with the character-length bit set. This separates the frame-length choices, the parity sense and the divide ratios from one another, and shows that synchronous mode ignores framing. Two bytes written back to back are checked with no cycle of slack. This exposes any idle gap at the refill. A standby pulse in the middle of a character checks the abort and the register reinitialisation.

// File: rtl/dstx_pkg.sv
package dstx_pkg;

  localparam int DATA_W   = 8;
  localparam int FRAME_W  = 12;
  localparam int BITCNT_W = 4;

  typedef struct packed {
    logic       sync;
    logic       chr7;
    logic       par_en;
    logic       par_odd;
    logic       stop2;
    logic       rsvd;
    logic [1:0] cks;
  } mode_t;

  function automatic int unsigned div_of(input logic [1:0] cks);
    return 32'd1 << {cks, 1'b0};
  endfunction

  function automatic logic parity_of(input logic [DATA_W-1:0] d, input logic chr7,
                                     input logic odd);
    logic [DATA_W-1:0] m;
    m = chr7 ? {1'b0, d[DATA_W-2:0]} : d;
    return (^m) ^ odd;
  endfunction

  function automatic logic [BITCNT_W-1:0] frame_len(input mode_t m);
    int n;
    if (m.sync) n = DATA_W;
    else n = 1 + (m.chr7 ? DATA_W - 1 : DATA_W) + (m.par_en ? 1 : 0) + (m.stop2 ? 2 : 1);
    return BITCNT_W'(n);
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(input mode_t m, input logic [DATA_W-1:0] d);
    logic [FRAME_W-1:0] f;
    int dlen;
    f = '1;
    if (m.sync) begin
      f[DATA_W-1:0] = d;
    end else begin
      dlen = m.chr7 ? DATA_W - 1 : DATA_W;
      f[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++)
        if (i < dlen) f[i+1] = d[i];
      if (m.par_en) f[dlen+1] = parity_of(d, m.chr7, m.par_odd);
    end
    return f;
  endfunction

endpackage

// File: rtl/dstx_regs.sv
module dstx_regs
  import dstx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  output logic [DATA_W-1:0] rd_data,
  output mode_t             mode,
  output logic [DATA_W-1:0] hold_data,
  output logic              tx_empty
);

  localparam logic [DATA_W-1:0] MODE_INIT = 8'h04;
  localparam logic [DATA_W-1:0] HOLD_INIT = 8'hFF;

  logic [DATA_W-1:0] mode_q;
  logic              wr_mode, wr_hold;

  assign wr_mode = wr_en && !addr;
  assign wr_hold = wr_en && addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_INIT;
      hold_data <= HOLD_INIT;
      tx_empty  <= 1'b1;
    end else if (standby) begin
      mode_q    <= MODE_INIT;
      hold_data <= HOLD_INIT;
      tx_empty  <= 1'b1;
    end else begin
      if (wr_mode) mode_q <= wr_data | MODE_INIT;
      if (wr_hold) begin
        hold_data <= wr_data;
        tx_empty  <= 1'b0;
      end else if (load) begin
        tx_empty  <= 1'b1;
      end
    end
  end

  assign mode    = mode_t'(mode_q);
  assign rd_data = addr ? hold_data : mode_q;

  assert_empty_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hold && !standby) |=> !tx_empty);

  assert_rsvd_reads_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !addr |-> rd_data[2]);

  assert_standby_init_R8: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (tx_empty && mode_q == MODE_INIT && hold_data == HOLD_INIT));

endmodule

// File: rtl/dstx_prescaler.sv
module dstx_prescaler
  import dstx_pkg::*;
#(
  parameter int MAX_DIV = 64,
  localparam int CNT_W  = $clog2(MAX_DIV)
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       clr,
  input  logic [1:0] cks,
  output logic       tick
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim  = CNT_W'(div_of(cks) - 1);
  assign tick = en && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr || !en || tick) cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/dstx_shifter.sv
module dstx_shifter
  import dstx_pkg::*;
#(
  parameter int OVS    = 16,
  localparam int SUB_W = $clog2(OVS)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  mode_t             mode,
  input  logic              tick,
  output logic              load,
  output logic              busy,
  output logic              frame_end,
  output logic [1:0]        cks_q,
  output logic              txd,
  output logic              sclk
);

  logic [FRAME_W-1:0]  frame;
  logic [BITCNT_W-1:0] bitn, nbits_q;
  logic [SUB_W-1:0]    sub, sub_last;
  logic                sync_q;
  logic                bit_end, last_bit;
  logic                unused_mode_rsvd;

  assign unused_mode_rsvd = mode.rsvd;
  assign sub_last  = sync_q ? SUB_W'(1) : SUB_W'(OVS - 1);
  assign bit_end   = busy && tick && (sub == sub_last);
  assign last_bit  = (bitn == nbits_q - 1'b1);
  assign frame_end = bit_end && last_bit;
  assign load      = hold_full && !clear && (!busy || frame_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; frame <= '1; bitn <= '0; nbits_q <= '0;
      sub <= '0; sync_q <= 1'b0; cks_q <= '0;
    end else if (clear) begin
      busy <= 1'b0; frame <= '1; bitn <= '0; nbits_q <= '0;
      sub <= '0; sync_q <= 1'b0; cks_q <= '0;
    end else if (load) begin
      busy    <= 1'b1;
      frame   <= build_frame(mode, hold_data);
      nbits_q <= frame_len(mode);
      bitn    <= '0;
      sub     <= '0;
      sync_q  <= mode.sync;
      cks_q   <= mode.cks;
    end else if (bit_end) begin
      sub <= '0;
      if (last_bit) begin
        busy <= 1'b0;
      end else begin
        frame <= {1'b1, frame[FRAME_W-1:1]};
        bitn  <= bitn + 1'b1;
      end
    end else if (tick) begin
      sub <= sub + 1'b1;
    end
  end

  assign txd  = busy ? frame[0] : 1'b1;
  assign sclk = !(busy && sync_q && (sub[0] == 1'b0));

  assert_load_needs_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> hold_full);

  assert_start_low_R4: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (load && !mode.sync) |=> !txd);

  assert_gapless_refill_R7: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (frame_end && hold_full) |=> busy);

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load) |=> (txd && sclk) || busy);

endmodule

// File: rtl/dual_serial_tx.sv
module dual_serial_tx
  import dstx_pkg::*;
#(
  parameter int OVS     = 16,
  parameter int MAX_DIV = 64
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       standby,
  input  logic       reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       txd,
  output logic       sclk,
  output logic       tx_empty
);

  mode_t             mode;
  logic [DATA_W-1:0] hold_data;
  logic              load, busy, frame_end, tick;
  logic [1:0]        cks_q;
  logic              unused_frame_end;

  assign unused_frame_end = frame_end;

  dstx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .standby(standby),
    .addr(reg_addr), .wr_en(reg_wr), .wr_data(reg_wdata),
    .load(load), .rd_data(reg_rdata), .mode(mode),
    .hold_data(hold_data), .tx_empty(tx_empty)
  );

  dstx_prescaler #(.MAX_DIV(MAX_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(busy), .clr(load),
    .cks(cks_q), .tick(tick)
  );

  dstx_shifter #(.OVS(OVS)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(standby),
    .hold_full(!tx_empty), .hold_data(hold_data), .mode(mode),
    .tick(tick), .load(load), .busy(busy), .frame_end(frame_end),
    .cks_q(cks_q), .txd(txd), .sclk(sclk)
  );

endmodule

// File: tb/dual_serial_tx_tb.sv
module dual_serial_tx_tb;

  logic clk = 0, rst_n = 0, standby = 0, reg_addr = 0, reg_wr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic txd, sclk, tx_empty;
  int ran = 0, failed = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_serial_tx u_dut (
    .clk(clk), .rst_n(rst_n), .standby(standby), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .txd(txd), .sclk(sclk), .tx_empty(tx_empty)
  );

  // {mode, data}
  localparam logic [15:0] VEC [7] = '{
    16'h00A5, 16'h603B, 16'h390F, 16'h4AFF, 16'h8096, 16'hC181, 16'h335A
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ran++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_chk(input logic a, input logic [7:0] exp, input string tag);
    @(negedge clk); reg_addr = a; #2;
    chk(tag, reg_rdata, exp);
  endtask

  function automatic int bit_time(input logic [7:0] m);
    int dv;
    dv = 1;
    for (int i = 0; i < m[1:0]; i++) dv = dv * 4;
    return m[7] ? 2 * dv : 16 * dv;
  endfunction

  task automatic exp_frame(input logic [7:0] m, input logic [7:0] d,
                           output logic [11:0] bits, output int n);
    logic p;
    int dl;
    bits = '1;
    if (m[7]) begin
      bits[7:0] = d; n = 8;
    end else begin
      n = 0; p = 0;
      bits[n] = 0; n++;
      dl = m[6] ? 7 : 8;
      for (int i = 0; i < dl; i++) begin bits[n] = d[i]; p = p ^ d[i]; n++; end
      if (m[5]) begin bits[n] = p ^ m[4]; n++; end
      n = n + (m[3] ? 2 : 1);
    end
  endtask

  // Entered at the middle of bit 0; leaves at the middle of the bit slot after the last.
  task automatic check_bits(input logic [11:0] bits, input int n, input int b,
                            input logic sync, input string tag);
    for (int k = 0; k < n; k++) begin
      chk({tag, " txd"}, txd, bits[k]);
      if (sync) begin
        chk({tag, " sclk high R6"}, sclk, 1'b1);
        repeat (b / 2) @(negedge clk);
        if (k < n - 1) chk({tag, " sclk low R6"}, sclk, 1'b0);
        repeat (b - b / 2) @(negedge clk);
      end else begin
        chk({tag, " sclk async R6"}, sclk, 1'b1);
        repeat (b) @(negedge clk);
      end
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", ran, failed);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      ran++; failed++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [11:0] bits, bits2;
    int n, n2, b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_chk(0, 8'h04, "R1 mode reset");
    rd_chk(1, 8'hFF, "R1 hold reset");
    chk("R1 empty", tx_empty, 1'b1);
    chk("R1 txd", txd, 1'b1);
    chk("R1 sclk", sclk, 1'b1);

    // R2 reserved bit reads one
    wr(0, 8'h00); rd_chk(0, 8'h04, "R2 rsvd set");
    wr(0, 8'hFB); rd_chk(0, 8'hFF, "R2 all ones");
    wr(0, 8'h00);

    // vector table: R4 R5 R6
    for (int v = 0; v < 7; v++) begin
      logic [7:0] m, d;
      m = VEC[v][15:8]; d = VEC[v][7:0];
      b = bit_time(m);
      exp_frame(m, d, bits, n);
      wr(0, m);
      rd_chk(0, m | 8'h04, "R2 mode readback");
      wr(1, d);
      chk("R3 empty cleared", tx_empty, 1'b0);
      repeat (1 + b / 2) @(negedge clk);
      chk("R3 empty after move", tx_empty, 1'b1);
      check_bits(bits, n, b, m[7], m[7] ? "R6 sync" : "R4 R5 async");
      chk("R1 idle txd", txd, 1'b1);
      chk("R1 idle sclk", sclk, 1'b1);
      rd_chk(1, d, "R2 hold readback");
    end

    // R7 back to back
    wr(0, 8'h00);
    b = bit_time(8'h00);
    exp_frame(8'h00, 8'h3C, bits, n);
    exp_frame(8'h00, 8'hC3, bits2, n2);
    wr(1, 8'h3C);
    wr(1, 8'hC3);
    repeat (b / 2 - 1) @(negedge clk);
    chk("R3 second byte waits", tx_empty, 1'b0);
    check_bits(bits, n, b, 1'b0, "R7 first");
    check_bits(bits2, n2, b, 1'b0, "R7 second");
    chk("R7 idle after", txd, 1'b1);

    // R8 standby mid-character
    wr(0, 8'h31);
    wr(1, 8'h00);
    repeat (20) @(negedge clk);
    chk("R8 shifting before standby", txd, 1'b0);
    standby = 1;
    reg_addr = 0; reg_wdata = 8'hF3; reg_wr = 1;
    @(negedge clk);
    @(negedge clk);
    reg_wr = 0;
    standby = 0;
    chk("R8 txd released", txd, 1'b1);
    chk("R8 empty", tx_empty, 1'b1);
    rd_chk(0, 8'h04, "R8 mode init, write ignored");
    rd_chk(1, 8'hFF, "R8 hold init");
    repeat (100) @(negedge clk);
    chk("R8 line stays idle", txd, 1'b1);
    chk("R8 sclk idle", sclk, 1'b1);

    done = 1;
    summary();
    $finish;
  end

endmodule